// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits between a serial-bus memory slave controller and the byte array of a non-volatile store. The controller hands it a start address once the two address bytes of a write command have arrived. It then hands over every data byte it acknowledges. The block keeps these bytes in a one-row page latch, with one valid flag per byte offset. The row part of the start address is captured once and stays fixed. Only the in-row offset advances after each byte, so a long burst wraps back to the start of the row and replaces bytes it latched earlier.

The controller reports how each command ends with one of two strobes. One marks a STOP that came in the slot right after an acknowledged data byte. The other marks a STOP at any other point. The first strobe, if at least one byte is latched, starts a programming cycle. The block raises `busy` and waits a parameterised number of clock cycles that stands for the cell write time. It then drives each latched byte onto a synchronous array write port, one per clock, lowest offset first. After the last byte it drops `busy` with an empty latch. While `busy` is high every request from the controller is ignored. The second strobe throws the latched bytes away. Upstream logic has already handled write protection by never acknowledging a protected data byte.

Top module: `pgbuf_programmer`

## Requirements
- R1: Out of reset `busy` and `arr_we` are 0 and nothing is latched.
- R2: A pulse on `addr_load` sets the row to `addr_in[14:6]` and the write offset to `addr_in[5:0]`. It also clears every latched byte. Every array write of the following cycle goes to that row: `arr_addr[14:6]` equals the captured row.
- R3: Each `byte_push` stores `byte_in` at the current offset, marks that offset valid and adds one to the offset modulo 64. Past offset 63 the offset returns to 0, and a later byte at an offset replaces the earlier one.
- R4: A `stop_commit` pulse while idle with at least one byte latched raises `busy` on the next clock edge.
- R5: A `stop_discard` pulse clears every latched byte. A later `stop_commit` with no new bytes starts nothing.
- R6: A `stop_commit` pulse with no byte latched leaves `busy` low and writes nothing.
- R7: After `busy` rises, exactly `WRITE_CYCLES` cycles pass with `arr_we` low before the first write. While `busy` is high, `addr_load`, `byte_push`, `stop_commit` and `stop_discard` have no effect.
- R8: After that wait, `arr_we` is high on consecutive cycles, one cycle for each valid offset and none for any other offset. The offsets come in ascending order. `arr_wdata` is the last byte latched at that offset.
- R9: `busy` falls in the cycle right after the last write, and the latch is then empty: a further `stop_commit` with no new bytes starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Start address of a write command is valid |
| addr_in | input | ADDR_W | Start address (row in upper bits, offset in low OFF_W bits) |
| byte_push | input | 1 | One acknowledged data byte is valid |
| byte_in | input | DATA_W | Data byte |
| stop_commit | input | 1 | STOP seen directly after an acknowledged data byte |
| stop_discard | input | 1 | STOP seen at any other point |
| busy | output | 1 | Programming cycle in progress; the bus side must not respond |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
On every cycle the assertions check several things. Writes happen only while busy. Once writing starts they are back to back, with offsets rising inside a single row. The wait before the first write is exactly the programmed length. A commit starts a cycle only when the latch holds data. Busy falls only straight after a write. Which bytes are written, and the data each one carries, are shown only by the bench scenarios, checked against a behavioural model: roll-over replacement past the row end, discarding by a misplaced STOP, clearing by a new address, and requests ignored during a cycle.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    localparam int unsigned DEF_ADDR_W       = 15;
    localparam int unsigned DEF_OFF_W        = 6;
    localparam int unsigned DEF_DATA_W       = 8;
    // 10 ms at a 250 MHz system clock
    localparam int unsigned DEF_WRITE_CYCLES = 2_500_000;

    typedef enum logic [1:0] {
        SEQ_COLLECT = 2'd0,
        SEQ_SETTLE  = 2'd1,
        SEQ_PROGRAM = 2'd2
    } seq_state_e;

    // width of a counter that must reach n-1
    function automatic int unsigned count_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pgbuf_latch.sv
module pgbuf_latch
    import pgbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned OFF_W  = DEF_OFF_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_en,
    input  logic [ADDR_W-1:0]         load_addr,
    input  logic                      push_en,
    input  logic [DATA_W-1:0]         push_data,
    input  logic                      drop_en,
    input  logic                      retire_en,
    input  logic [OFF_W-1:0]          retire_off,
    input  logic [OFF_W-1:0]          rd_off,
    output logic [DATA_W-1:0]         rd_data,
    output logic [(1<<OFF_W)-1:0]     valid_mask,
    output logic [ADDR_W-OFF_W-1:0]   row
);
    localparam int unsigned PAGE_BYTES = 1 << OFF_W;
    localparam int unsigned ROW_W      = ADDR_W - OFF_W;

    logic [DATA_W-1:0]     page_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;
    logic [OFF_W-1:0]      ptr_q;
    logic [ROW_W-1:0]      row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            ptr_q   <= '0;
            row_q   <= '0;
        end else if (load_en) begin
            row_q   <= load_addr[ADDR_W-1:OFF_W];
            ptr_q   <= load_addr[OFF_W-1:0];
            valid_q <= '0;
        end else if (push_en) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q          <= ptr_q + 1'b1;
        end else if (drop_en) begin
            valid_q <= '0;
        end else if (retire_en) begin
            valid_q[retire_off] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en && !load_en) begin
            page_q[ptr_q] <= push_data;
        end
    end

    assign rd_data    = page_q[rd_off];
    assign valid_mask = valid_q;
    assign row        = row_q;

endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer
    import pgbuf_pkg::*;
#(
    parameter int unsigned CYCLES = DEF_WRITE_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = count_width(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == CW'(CYCLES - 1));

endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
    import pgbuf_pkg::*;
#(
    parameter int unsigned OFF_W = DEF_OFF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit_req,
    input  logic [(1<<OFF_W)-1:0] valid_mask,
    input  logic                  expire,
    output logic                  busy,
    output logic                  timer_run,
    output logic                  wr_fire,
    output logic [OFF_W-1:0]      wr_off
);
    localparam int unsigned PAGE_BYTES = 1 << OFF_W;

    seq_state_e            state_q, state_d;
    logic [OFF_W-1:0]      pick;
    logic [PAGE_BYTES-1:0] rest;

    // lowest set offset of the valid mask
    always_comb begin
        pick = '0;
        for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
            if (valid_mask[i]) pick = OFF_W'(i);
        end
        rest       = valid_mask;
        rest[pick] = 1'b0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_COLLECT: if (commit_req && |valid_mask) state_d = SEQ_SETTLE;
            SEQ_SETTLE:  if (expire)                    state_d = SEQ_PROGRAM;
            SEQ_PROGRAM: if (rest == '0)                state_d = SEQ_COLLECT;
            default:                                    state_d = SEQ_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_COLLECT;
        else     state_q <= state_d;
    end

    assign busy      = (state_q != SEQ_COLLECT);
    assign timer_run = (state_q == SEQ_SETTLE);
    assign wr_fire   = (state_q == SEQ_PROGRAM) && |valid_mask;
    assign wr_off    = pick;

endmodule

// File: rtl/pgbuf_programmer.sv
module pgbuf_programmer
    import pgbuf_pkg::*;
#(
    parameter int unsigned ADDR_W       = DEF_ADDR_W,
    parameter int unsigned DATA_W       = DEF_DATA_W,
    parameter int unsigned OFF_W        = DEF_OFF_W,
    parameter int unsigned WRITE_CYCLES = DEF_WRITE_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_push,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_commit,
    input  logic              stop_discard,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int unsigned PAGE_BYTES = 1 << OFF_W;
    localparam int unsigned ROW_W      = ADDR_W - OFF_W;

    logic                  busy_w;
    logic                  accept;
    logic                  valid_any;
    logic [PAGE_BYTES-1:0] valid_mask;
    logic [ROW_W-1:0]      row;
    logic                  timer_run;
    logic                  expire;
    logic                  wr_fire;
    logic [OFF_W-1:0]      wr_off;
    logic [DATA_W-1:0]     rd_data;

    // requests from the bus side count only while idle
    assign accept    = !busy_w;
    assign valid_any = |valid_mask;

    pgbuf_latch #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk        (clk),
        .rst        (rst),
        .load_en    (addr_load && accept),
        .load_addr  (addr_in),
        .push_en    (byte_push && accept),
        .push_data  (byte_in),
        .drop_en    (stop_discard && accept),
        .retire_en  (wr_fire),
        .retire_off (wr_off),
        .rd_off     (wr_off),
        .rd_data    (rd_data),
        .valid_mask (valid_mask),
        .row        (row)
    );

    pgbuf_timer #(
        .CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (timer_run),
        .expire (expire)
    );

    pgbuf_seq #(
        .OFF_W (OFF_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .commit_req (stop_commit && accept),
        .valid_mask (valid_mask),
        .expire     (expire),
        .busy       (busy_w),
        .timer_run  (timer_run),
        .wr_fire    (wr_fire),
        .wr_off     (wr_off)
    );

    assign busy      = busy_w;
    assign arr_we    = wr_fire;
    assign arr_addr  = {row, wr_off};
    assign arr_wdata = rd_data;

endmodule

// File: rtl/pgbuf_programmer_sva.sv
module pgbuf_programmer_sva #(
    parameter int unsigned ADDR_W       = 15,
    parameter int unsigned OFF_W        = 6,
    parameter int unsigned WRITE_CYCLES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              stop_commit,
    input logic              valid_any
);
    // busy cycles seen so far in this cycle without any write yet
    logic [31:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy)  wait_cnt <= '0;
        else if (!arr_we)  wait_cnt <= wait_cnt + 1;
    end

    a_r1_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    a_r4_commit_starts: assert property (@(posedge clk) disable iff (rst)
        (!busy && stop_commit && valid_any) |=> busy);

    a_r6_empty_commit_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && stop_commit && !valid_any) |=> !busy);

    a_r7_wait_length: assert property (@(posedge clk) disable iff (rst)
        (arr_we && !$past(arr_we)) |-> (wait_cnt == 32'(WRITE_CYCLES)));

    a_r8_back_to_back: assert property (@(posedge clk) disable iff (rst)
        ($past(arr_we) && busy) |-> arr_we);

    a_r8_ascending: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])));

    a_r2_same_row: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])));

    a_r9_fall_after_write: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(arr_we));

endmodule

bind pgbuf_programmer pgbuf_programmer_sva #(
    .ADDR_W       (ADDR_W),
    .OFF_W        (OFF_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .arr_we      (arr_we),
    .arr_addr    (arr_addr),
    .stop_commit (stop_commit),
    .valid_any   (valid_any)
);

// File: tb/pgbuf_programmer_tb.sv
`timescale 1ns/1ps
module pgbuf_programmer_tb;
    localparam int W = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_load = 1'b0;
    logic [14:0] addr_in = '0;
    logic        byte_push = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        stop_commit = 1'b0;
    logic        stop_discard = 1'b0;
    logic        busy, arr_we;
    logic [14:0] arr_addr;
    logic [7:0]  arr_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int wr_count = 0;
    int first_addr = -1;
    bit finished = 0;

    always #2 clk = ~clk;

    pgbuf_programmer #(.WRITE_CYCLES(W)) u_dut (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
        .byte_push(byte_push), .byte_in(byte_in), .stop_commit(stop_commit),
        .stop_discard(stop_discard), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    // behavioural reference
    int        m_state = 0;   // 0 idle, 1 waiting, 2 writing
    int        m_t = 0;
    int        m_row = 0;
    int        m_ptr = 0;
    bit [63:0] m_valid = '0;
    int        m_page [64];

    function automatic int lowest(input bit [63:0] v);
        for (int i = 0; i < 64; i++) if (v[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_t = 0; m_valid = '0; m_ptr = 0; m_row = 0;
        end else begin
            case (m_state)
                0: begin
                    if (addr_load) begin
                        m_row = int'(addr_in) / 64; m_ptr = int'(addr_in) % 64; m_valid = '0;
                    end else if (byte_push) begin
                        m_page[m_ptr] = int'(byte_in); m_valid[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 64;
                    end else if (stop_discard) begin
                        m_valid = '0;
                    end else if (stop_commit && m_valid != 0) begin
                        m_state = 1; m_t = 0;
                    end
                end
                1: begin
                    m_t++;
                    if (m_t == W) m_state = 2;
                end
                default: begin
                    m_valid[lowest(m_valid)] = 1'b0;
                    if (m_valid == 0) m_state = 0;
                end
            endcase
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R7", "busy", int'(busy), (m_state != 0) ? 1 : 0);
            check("R8", "arr_we", int'(arr_we), (m_state == 2) ? 1 : 0);
            if (m_state == 2) begin
                check("R8", "arr_addr", int'(arr_addr), m_row * 64 + lowest(m_valid));
                check("R8", "arr_wdata", int'(arr_wdata), m_page[lowest(m_valid)]);
            end
            if (arr_we) begin
                if (wr_count == 0) first_addr = int'(arr_addr);
                wr_count++;
            end
        end
    end

    task automatic pulse_load(input int a);
        @(negedge clk); addr_load <= 1'b1; addr_in <= 15'(a);
        @(negedge clk); addr_load <= 1'b0;
    endtask
    task automatic pulse_push(input int d);
        @(negedge clk); byte_push <= 1'b1; byte_in <= 8'(d);
        @(negedge clk); byte_push <= 1'b0;
    endtask
    task automatic pulse_commit();
        @(negedge clk); stop_commit <= 1'b1;
        @(negedge clk); stop_commit <= 1'b0;
    endtask
    task automatic pulse_discard();
        @(negedge clk); stop_discard <= 1'b1;
        @(negedge clk); stop_discard <= 1'b0;
    endtask
    task automatic settle_and_count(input string tag, input int exp_writes);
        repeat (W + 72) @(negedge clk);
        check(tag, "write count", wr_count, exp_writes);
        check(tag, "busy after cycle", int'(busy), 0);
        wr_count = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst <= 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy at reset", int'(busy), 0);
        check("R1", "arr_we at reset", int'(arr_we), 0);

        // single byte; R2 R4
        pulse_load(15'h1234); pulse_push(8'hA5);
        wr_count = 0;
        @(negedge clk); stop_commit <= 1'b1;
        @(negedge clk); stop_commit <= 1'b0;
        check("R4", "busy after commit", int'(busy), 1);
        settle_and_count("R4", 1);
        check("R2", "row of write", first_addr / 64, 'h1234 / 64);

        // short burst in one row; R8
        pulse_load(16'h0103);
        for (int i = 0; i < 5; i++) pulse_push(8'h30 + i);
        wr_count = 0; pulse_commit();
        settle_and_count("R8", 5);
        check("R8", "first write offset", first_addr % 64, 3);

        // roll-over past row end; R3
        pulse_load(5 * 64 + 60);
        for (int i = 0; i < 70; i++) pulse_push(i);
        wr_count = 0; pulse_commit();
        settle_and_count("R3", 64);
        check("R2", "row kept through wrap", first_addr / 64, 5);
        check("R3", "wrap writes start at offset", first_addr % 64, 0);

        // misplaced STOP discards; R5
        pulse_load(15'h0200);
        for (int i = 0; i < 3; i++) pulse_push(8'hC0 + i);
        pulse_discard();
        wr_count = 0; pulse_commit();
        @(negedge clk);
        check("R5", "busy after discarded commit", int'(busy), 0);
        settle_and_count("R5", 0);

        // commit with nothing latched; R6
        pulse_load(15'h0300);
        wr_count = 0; pulse_commit();
        @(negedge clk);
        check("R6", "busy after empty commit", int'(busy), 0);
        settle_and_count("R6", 0);

        // requests during busy ignored; R7
        pulse_load(15'h0040); pulse_push(8'h11);
        wr_count = 0; pulse_commit();
        pulse_load(15'h7FC0); pulse_push(8'h99); pulse_push(8'h98);
        pulse_discard(); pulse_commit();
        settle_and_count("R7", 1);
        check("R7", "address unchanged by ignored load", first_addr, 'h0040);

        // latch empty after cycle; R9
        wr_count = 0; pulse_commit();
        settle_and_count("R9", 0);

        // new address clears earlier bytes; R2
        pulse_load(15'h0500); pulse_push(8'h01); pulse_push(8'h02);
        pulse_load(15'h0A0A); pulse_push(8'h77);
        wr_count = 0; pulse_commit();
        settle_and_count("R2", 1);
        check("R2", "reload target", first_addr, 'h0A0A);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule